// File: doc/BRIEF.md
# Four-Way Instruction Cache

This block is a read-only instruction cache holding 8 KiB of code in 64 sets of four ways, with 32-byte lines. A processor front end presents a 32-bit byte address on the fetch port. If the line is resident, the aligned 32-bit instruction word comes back on the response port one cycle later. If the line is absent, the cache reads the whole line from backing memory as eight word reads, starting at the line base. It stores the line in a victim way, then answers with the requested word. Every response carries a hit flag and an access cost in cycles: one for a hit, and one non-sequential plus seven sequential memory times for a refill.

Each way keeps only a tag. A way is empty when its tag holds a marker that no aligned address can produce, so there is no separate valid bit. A maintenance port takes a 12-bit command code and an address. Code 0x750 empties the whole cache. Code 0x751 empties the way holding the line of the given address. Every other code is accepted and ignored. The victim way on a miss comes from one of two selectors: a per-set rotating counter, or a free-running pseudo-random sequence. The plain control input `repl_rr` picks between them.

The fetch, refill-request and maintenance ports use valid/ready handshakes. A fetch is taken when `fetch_valid` and `fetch_ready` are both high. `fetch_ready` stays low from the accepted miss until its response, and while a maintenance command is waiting. A refill request holds its address and sequential flag until `mem_req_ready` is seen. Only one refill read is outstanding at a time, and memory returns its data with a one-cycle `mem_rsp_valid` pulse. The response port and the memory-data port have no back-pressure.

Top module: `icache4w`

## Requirements
- R1: After reset, every way of every set is empty. An address with tag 0 misses. `fetch_ready` and `maint_ready` are high, and `rsp_valid` and `mem_req_valid` are low. The rotating counters start at 0 and the random state starts at 44203.
- R2: The tag is address bits [31:11], the set is bits [10:5], and the word within the line is bits [4:2]. Bits [1:0] are ignored. All 64 sets can hold a line at the same time.
- R3: On a hit, `rsp_valid` pulses in the cycle after acceptance with the stored word, `rsp_hit`=1 and `rsp_cycles`=1.
- R4: On a miss, exactly eight requests are issued, to line base + 4·k for k = 0..7 in order. `mem_req_seq` is 0 for k=0 and 1 for the rest. A stalled request keeps its address and flag.
- R5: After the eighth data beat, `rsp_valid` pulses with the requested word, `rsp_hit`=0 and `rsp_cycles`=NSEQ_COST+7·SEQ_COST (19 by default). The line then hits.
- R6: Four distinct tags in one set are all resident at once. A lookup takes the lowest-numbered matching way.
- R7: With `repl_rr`=1, the victim is the set's 2-bit counter, which then advances by one (mod 4) on each miss in that set.
- R8: With `repl_rr`=0, each miss updates the state s to s ^ 17·s ^ 7·s (mod 2^32), and the victim is bits [18:17] of the new state.
- R9: Code 0x750 empties all 256 ways. Every previously resident line then misses.
- R10: Code 0x751 empties only the first way matching the address's tag and set. Other lines of the set stay resident. An address that matches nothing changes nothing.
- R11: Any other code is accepted and leaves every resident line hitting.
- R12: `maint_ready` is low during a refill, so a command presented then waits and takes effect after the refill response. While `maint_valid` is high in the idle state, `fetch_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; empties the cache |
| repl_rr | input | 1 | 1: rotating victim per set; 0: pseudo-random victim |
| fetch_valid | input | 1 | Fetch request present |
| fetch_ready | output | 1 | Fetch request can be taken |
| fetch_addr | input | 32 | Byte address of the instruction word |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | 32 | Instruction word |
| rsp_hit | output | 1 | 1 when the line was resident |
| rsp_cycles | output | COST_W | Access cost in cycles |
| mem_req_valid | output | 1 | Refill read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Word address of the refill read |
| mem_req_seq | output | 1 | 0 for the first read of a line, 1 for the others |
| mem_rsp_valid | input | 1 | Refill data beat |
| mem_rsp_data | input | 32 | Refill data |
| maint_valid | input | 1 | Maintenance command present |
| maint_ready | output | 1 | Command can be taken |
| maint_code | input | 12 | Command code |
| maint_addr | input | 32 | Address for line invalidation |

## Verification
A wrong tag entry shows at the ports on the next fetch to that set. Either a line reports a hit it should not have, or it starts an unexpected eight-read refill. Sweeping one line into every set and reading all of them back exposes a bad index or tag split within one pass. A victim counter or random state that drifts evicts the wrong way. The bench detects this at the first probe of the other three tags of that set, right after the miss. A sequencer fault shows as a bad request address, a bad sequential flag or a wrong beat count on the refill of the first miss.

// File: rtl/icache_pkg.sv
package icache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT
  } fill_state_e;

  localparam int CODE_W = 12;
  localparam logic [CODE_W-1:0] CMD_FLUSH_ALL  = 12'h750;
  localparam logic [CODE_W-1:0] CMD_FLUSH_LINE = 12'h751;

  // One step of the victim pseudo-random sequence.
  function automatic logic [31:0] rng_step(input logic [31:0] s);
    return s ^ (s * 32'd17) ^ (s * 32'd7);
  endfunction

endpackage

// File: rtl/icache_tags.sv
module icache_tags #(
  parameter int SETS  = 64,
  parameter int WAYS  = 4,
  parameter int TAG_W = 21,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] look_set,
  input  logic [TAG_W-1:0] look_tag,
  output logic             hit,
  output logic [WAY_W-1:0] hit_way,
  input  logic             fill_en,
  input  logic [SET_W-1:0] fill_set,
  input  logic [WAY_W-1:0] fill_way,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             drop_en,
  input  logic [SET_W-1:0] drop_set,
  input  logic [WAY_W-1:0] drop_way,
  input  logic             drop_all
);

  // Entry is {tag, bit0}; a real line keeps bit0 clear, an empty way holds 1.
  localparam logic [TAG_W:0] EMPTY = {{TAG_W{1'b0}}, 1'b1};

  logic [TAG_W:0] tag_q [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (rst || drop_all) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          tag_q[s][w] <= EMPTY;
    end else begin
      if (fill_en) tag_q[fill_set][fill_way] <= {fill_tag, 1'b0};
      if (drop_en) tag_q[drop_set][drop_way] <= EMPTY;
    end
  end

  // Lowest-numbered matching way wins.
  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (tag_q[look_set][w] == {look_tag, 1'b0}) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
  end

  a_r9_all_clear: assert property (@(posedge clk) disable iff (rst)
    drop_all |=> !hit);

  a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !hit);

endmodule

// File: rtl/icache_victim.sv
module icache_victim #(
  parameter int SETS = 64,
  parameter int WAYS = 4,
  parameter logic [31:0] SEED = 32'd44203,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rr_mode,
  input  logic [SET_W-1:0] set,
  input  logic             advance,
  output logic [WAY_W-1:0] way
);

  import icache_pkg::*;

  logic [WAY_W-1:0] cnt_q [SETS];
  logic [31:0]      seed_q;
  logic [31:0]      seed_nx;

  assign seed_nx = rng_step(seed_q);
  assign way     = rr_mode ? cnt_q[set] : seed_nx[17 +: WAY_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) cnt_q[s] <= '0;
      seed_q <= SEED;
    end else if (advance) begin
      if (rr_mode) cnt_q[set] <= cnt_q[set] + WAY_W'(1);
      else         seed_q     <= seed_nx;
    end
  end

  a_r8_seed_holds: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(seed_q));

  a_r7_rr_keeps_random: assert property (@(posedge clk) disable iff (rst)
    (advance && rr_mode) |=> $stable(seed_q));

endmodule

// File: rtl/icache_data.sv
module icache_data #(
  parameter int SETS       = 64,
  parameter int WAYS       = 4,
  parameter int LINE_WORDS = 8,
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int WORD_W = $clog2(LINE_WORDS),
  localparam int IDX_W  = SET_W + WAY_W + WORD_W,
  localparam int DEPTH  = SETS * WAYS * LINE_WORDS
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [31:0]       wr_data,
  input  logic [SET_W-1:0]  rd_set,
  input  logic [WAY_W-1:0]  rd_way,
  input  logic [WORD_W-1:0] rd_word,
  output logic [31:0]       rd_data
);

  logic [31:0]      mem [DEPTH];
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_idx;

  assign wr_idx  = {wr_set, wr_way, wr_word};
  assign rd_idx  = {rd_set, rd_way, rd_word};
  assign rd_data = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

endmodule

// File: rtl/icache4w.sv
module icache4w #(
  parameter int SETS       = 64,
  parameter int WAYS       = 4,
  parameter int LINE_WORDS = 8,
  parameter int NSEQ_COST  = 5,
  parameter int SEQ_COST   = 2,
  parameter int COST_W     = 8,
  parameter logic [31:0] SEED = 32'd44203
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              repl_rr,
  input  logic              fetch_valid,
  output logic              fetch_ready,
  input  logic [31:0]       fetch_addr,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  output logic              rsp_hit,
  output logic [COST_W-1:0] rsp_cycles,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [31:0]       mem_req_addr,
  output logic              mem_req_seq,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  input  logic              maint_valid,
  output logic              maint_ready,
  input  logic [11:0]       maint_code,
  input  logic [31:0]       maint_addr
);

  import icache_pkg::*;

  localparam int SET_W   = $clog2(SETS);
  localparam int WAY_W   = $clog2(WAYS);
  localparam int WORD_W  = $clog2(LINE_WORDS);
  localparam int OFF_W   = WORD_W + 2;
  localparam int TAG_LSB = OFF_W + SET_W;
  localparam int TAG_W   = 32 - TAG_LSB;
  localparam logic [COST_W-1:0] HIT_COST  = COST_W'(1);
  localparam logic [COST_W-1:0] MISS_COST = COST_W'(NSEQ_COST + (LINE_WORDS - 1) * SEQ_COST);

  fill_state_e       state_q;
  logic [TAG_W-1:0]  tag_q;
  logic [SET_W-1:0]  set_q;
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] beat_q;
  logic [WAY_W-1:0]  victim_q;
  logic [31:0]       keep_q;

  logic              idle, fetch_fire, maint_fire, last_beat, beat_wr;
  logic [SET_W-1:0]  look_set;
  logic [TAG_W-1:0]  look_tag;
  logic              hit;
  logic [WAY_W-1:0]  hit_way, victim_way;
  logic [31:0]       rd_data;
  logic              drop_all, drop_en, advance;
  logic              unused_bits;

  assign unused_bits = ^{fetch_addr[1:0], maint_addr[OFF_W-1:0]};

  assign idle        = (state_q == ST_IDLE);
  assign maint_ready = idle;
  assign fetch_ready = idle && !maint_valid;
  assign maint_fire  = maint_valid && idle;
  assign fetch_fire  = fetch_valid && fetch_ready;

  // One lookup path, shared; maintenance takes it first when idle.
  assign look_set = maint_valid ? maint_addr[OFF_W +: SET_W]   : fetch_addr[OFF_W +: SET_W];
  assign look_tag = maint_valid ? maint_addr[TAG_LSB +: TAG_W] : fetch_addr[TAG_LSB +: TAG_W];

  assign drop_all = maint_fire && (maint_code == CMD_FLUSH_ALL);
  assign drop_en  = maint_fire && (maint_code == CMD_FLUSH_LINE) && hit;
  assign advance  = fetch_fire && !hit;

  assign last_beat = (beat_q == WORD_W'(LINE_WORDS - 1));
  assign beat_wr   = (state_q == ST_WAIT) && mem_rsp_valid;

  assign mem_req_valid = (state_q == ST_REQ);
  assign mem_req_addr  = {tag_q, set_q, beat_q, 2'b00};
  assign mem_req_seq   = (beat_q != '0);

  icache_tags #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .look_set (look_set),
    .look_tag (look_tag),
    .hit      (hit),
    .hit_way  (hit_way),
    .fill_en  (beat_wr && last_beat),
    .fill_set (set_q),
    .fill_way (victim_q),
    .fill_tag (tag_q),
    .drop_en  (drop_en),
    .drop_set (look_set),
    .drop_way (hit_way),
    .drop_all (drop_all)
  );

  icache_victim #(.SETS(SETS), .WAYS(WAYS), .SEED(SEED)) u_victim (
    .clk     (clk),
    .rst     (rst),
    .rr_mode (repl_rr),
    .set     (look_set),
    .advance (advance),
    .way     (victim_way)
  );

  icache_data #(.SETS(SETS), .WAYS(WAYS), .LINE_WORDS(LINE_WORDS)) u_data (
    .clk     (clk),
    .wr_en   (beat_wr),
    .wr_set  (set_q),
    .wr_way  (victim_q),
    .wr_word (beat_q),
    .wr_data (mem_rsp_data),
    .rd_set  (look_set),
    .rd_way  (hit_way),
    .rd_word (fetch_addr[2 +: WORD_W]),
    .rd_data (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      tag_q      <= '0;
      set_q      <= '0;
      word_q     <= '0;
      beat_q     <= '0;
      victim_q   <= '0;
      keep_q     <= '0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      rsp_hit    <= 1'b0;
      rsp_cycles <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (fetch_fire) begin
            tag_q  <= look_tag;
            set_q  <= look_set;
            word_q <= fetch_addr[2 +: WORD_W];
            if (hit) begin
              rsp_valid  <= 1'b1;
              rsp_data   <= rd_data;
              rsp_hit    <= 1'b1;
              rsp_cycles <= HIT_COST;
            end else begin
              victim_q <= victim_way;
              beat_q   <= '0;
              state_q  <= ST_REQ;
            end
          end
        end
        ST_REQ: begin
          if (mem_req_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            if (beat_q == word_q) keep_q <= mem_rsp_data;
            if (last_beat) begin
              state_q    <= ST_IDLE;
              rsp_valid  <= 1'b1;
              rsp_data   <= (beat_q == word_q) ? mem_rsp_data : keep_q;
              rsp_hit    <= 1'b0;
              rsp_cycles <= MISS_COST;
            end else begin
              beat_q  <= beat_q + WORD_W'(1);
              state_q <= ST_REQ;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r4_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_seq)));

  a_r4_first_aligned: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_seq) |-> (mem_req_addr[OFF_W-1:0] == '0));

  a_r3_hit_cost: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> (rsp_cycles == HIT_COST));

  a_r5_miss_cost: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_cycles == MISS_COST));

  a_r12_busy_blocks: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (!fetch_ready && !maint_ready));

  a_r5_one_response: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

endmodule

// File: tb/icache4w_test.sv
`timescale 1ns/1ps
module icache4w_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        repl_rr = 1'b1;
  logic        fetch_valid = 1'b0;
  logic        fetch_ready;
  logic [31:0] fetch_addr = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        rsp_hit;
  logic [7:0]  rsp_cycles;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr;
  logic        mem_req_seq;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        maint_valid = 1'b0;
  logic        maint_ready;
  logic [11:0] maint_code = '0;
  logic [31:0] maint_addr = '0;

  always #2.5 clk = ~clk;

  icache4w uut (
    .clk(clk), .rst(rst), .repl_rr(repl_rr),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_hit(rsp_hit), .rsp_cycles(rsp_cycles),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_seq(mem_req_seq),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .maint_valid(maint_valid), .maint_ready(maint_ready),
    .maint_code(maint_code), .maint_addr(maint_addr)
  );

  int          checks = 0;
  int          fails  = 0;
  int          beats  = 0;
  logic [31:0] exp_base = '0;
  logic        stall = 1'b0;
  logic        pend = 1'b0;
  logic [31:0] pend_addr = '0;
  int          tick = 0;
  logic [31:0] seed_m = 32'd44203;

  localparam logic [20:0] TA = 21'h000000, TB = 21'h000002, TC = 21'h000100;
  localparam logic [20:0] TD = 21'h1FFFFF, TE = 21'h00AB0C, TF = 21'h012345;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return ({2'b00, a[31:2]} * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] mk(input logic [20:0] t, input int s, input int w);
    return {t, 6'(s), 3'(w), 2'b00};
  endfunction

  function automatic int rand_way();
    seed_m = seed_m ^ (seed_m * 32'd17) ^ (seed_m * 32'd7);
    return int'(seed_m[18:17]);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Backing memory: one outstanding read, data one cycle after acceptance.
  initial forever begin
    @(negedge clk);
    if (pend) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = mem_word(pend_addr);
      pend = 1'b0;
    end else begin
      mem_rsp_valid = 1'b0;
    end
    mem_req_ready = stall ? tick[0] : 1'b1;
    tick++;
    #1;
    if (mem_req_valid && mem_req_ready) begin
      check(mem_req_addr == exp_base + 32'(beats * 4), "R4 refill address", mem_req_addr, exp_base + 32'(beats * 4));
      check(mem_req_seq == (beats != 0), "R4 sequential flag", 32'(mem_req_seq), 32'(beats != 0));
      pend = 1'b1;
      pend_addr = mem_req_addr;
      beats++;
    end
  end

  task automatic do_fetch(input logic [31:0] a, input bit exp_hit, input string req);
    int n;
    exp_base = {a[31:5], 5'b0};
    beats = 0;
    @(negedge clk);
    fetch_valid = 1'b1;
    fetch_addr  = a;
    #1;
    while (!fetch_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    n = 0;
    do begin
      @(negedge clk);
      fetch_valid = 1'b0;
      n++;
    end while (!rsp_valid && n < 200);
    check(rsp_valid == 1'b1, {req, " response"}, 32'(rsp_valid), 32'd1);
    check(rsp_hit == exp_hit, {req, " hit flag"}, 32'(rsp_hit), 32'(exp_hit));
    check(rsp_data == mem_word(a), {req, " data"}, rsp_data, mem_word(a));
    if (exp_hit) begin
      check(n == 1, {req, " R3 hit latency"}, 32'(n), 32'd1);
      check(rsp_cycles == 8'd1, {req, " R3 hit cost"}, 32'(rsp_cycles), 32'd1);
      check(beats == 0, {req, " R3 no refill"}, 32'(beats), 32'd0);
    end else begin
      check(rsp_cycles == 8'd19, {req, " R5 miss cost"}, 32'(rsp_cycles), 32'd19);
      check(beats == 8, {req, " R4 beat count"}, 32'(beats), 32'd8);
    end
  endtask

  task automatic do_maint(input logic [11:0] code, input logic [31:0] a);
    @(negedge clk);
    maint_valid = 1'b1;
    maint_code  = code;
    maint_addr  = a;
    #1;
    while (!maint_ready) begin @(negedge clk); #1; end
    check(fetch_ready == 1'b0, "R12 fetch blocked by command", 32'(fetch_ready), 32'd0);
    @(posedge clk);
    @(negedge clk);
    maint_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [20:0] tg [4];
    int v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state at the ports
    check(fetch_ready == 1'b1, "R1 fetch_ready", 32'(fetch_ready), 32'd1);
    check(maint_ready == 1'b1, "R1 maint_ready", 32'(maint_ready), 32'd1);
    check(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 32'd0);
    check(mem_req_valid == 1'b0, "R1 mem_req_valid", 32'(mem_req_valid), 32'd0);

    // R1, R2: tag 0 misses after reset; one line into every set, then all hit
    for (int s = 0; s < 64; s++) do_fetch(mk(TA, s, s % 8), 1'b0, "R1 R2 sweep fill");
    for (int s = 0; s < 64; s++) do_fetch(mk(TA, s, 7 - (s % 8)) | 32'(s % 4), 1'b1, "R2 sweep hit");

    // R6, R7: four tags in set 5, rotating victim, with memory stalls
    stall = 1'b1;
    do_fetch(mk(TB, 5, 1), 1'b0, "R7 fill way1");
    do_fetch(mk(TC, 5, 2), 1'b0, "R7 fill way2");
    do_fetch(mk(TD, 5, 3), 1'b0, "R7 fill way3");
    do_fetch(mk(TA, 5, 4), 1'b1, "R6 way0 resident");
    do_fetch(mk(TB, 5, 5), 1'b1, "R6 way1 resident");
    do_fetch(mk(TC, 5, 6), 1'b1, "R6 way2 resident");
    do_fetch(mk(TD, 5, 7), 1'b1, "R6 way3 resident");
    do_fetch(mk(TE, 5, 0), 1'b0, "R7 evict way0");
    do_fetch(mk(TC, 5, 0), 1'b1, "R7 way2 kept");
    do_fetch(mk(TD, 5, 0), 1'b1, "R7 way3 kept");
    do_fetch(mk(TE, 5, 1), 1'b1, "R7 new line");
    do_fetch(mk(TA, 5, 2), 1'b0, "R7 evicted line misses");
    do_fetch(mk(TB, 5, 2), 1'b0, "R7 next victim way1");
    stall = 1'b0;

    // R8: random victim in sets 9 and 10
    for (int s = 9; s <= 10; s++) begin
      repl_rr = 1'b1;
      tg[0] = TA; tg[1] = TB; tg[2] = TC; tg[3] = TD;
      for (int w = 1; w < 4; w++) do_fetch(mk(tg[w], s, w), 1'b0, "R8 setup");
      repl_rr = 1'b0;
      v = rand_way();
      do_fetch(mk(TE, s, 0), 1'b0, "R8 random miss");
      for (int w = 0; w < 4; w++)
        if (w != v) do_fetch(mk(tg[w], s, 3), 1'b1, "R8 survivor");
      do_fetch(mk(tg[v], s, 3), 1'b0, "R8 random victim evicted");
      v = rand_way();
    end
    repl_rr = 1'b1;

    // R10, R11: line invalidation in set 20
    do_fetch(mk(TB, 20, 0), 1'b0, "R10 setup");
    do_maint(12'h751, mk(TF, 20, 0));
    do_fetch(mk(TA, 20, 1), 1'b1, "R10 no match no change");
    do_maint(12'h751, mk(TA, 20, 5) | 32'h3);
    do_fetch(mk(TB, 20, 2), 1'b1, "R10 other way kept");
    do_fetch(mk(TA, 20, 3), 1'b0, "R10 line dropped");
    do_maint(12'h752, mk(TB, 20, 0));
    do_maint(12'h761, mk(TA, 20, 0));
    do_maint(12'h000, mk(TA, 20, 0));
    do_fetch(mk(TB, 20, 4), 1'b1, "R11 other code ignored");
    do_fetch(mk(TA, 20, 4), 1'b1, "R11 other code ignored");

    // R9: flush all
    do_maint(12'h750, 32'h0);
    do_fetch(mk(TA, 30, 0), 1'b0, "R9 flushed set30");
    do_fetch(mk(TB, 20, 0), 1'b0, "R9 flushed set20");
    do_fetch(mk(TE, 5, 5), 1'b0, "R9 flushed set5");

    // R12: a command raised during a refill waits and then applies
    fork
      do_fetch(mk(TC, 40, 6), 1'b0, "R12 refill");
      begin
        repeat (3) @(negedge clk);
        #1;
        check(maint_ready == 1'b0, "R12 maint_ready low in refill", 32'(maint_ready), 32'd0);
        do_maint(12'h751, mk(TC, 40, 0));
      end
    join
    do_fetch(mk(TC, 40, 6), 1'b0, "R12 held command applied");
    do_fetch(mk(TC, 40, 2), 1'b1, "R12 refilled line hits");

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule